// File: doc/BRIEF.md
# Cache-to-Link Error Flag Mapper

This block translates error indications between a cache pipeline and the two link channels it serves. Inbound, it takes writeback and snoop-response messages from the inner cache, which carry only a single corrupt bit, and uses the message opcode to sort that bit into either a tag-level (denied) or a data-level (corrupt) error. It also accepts fill data from the outer level, which carries separate denied and corrupt bits. Either source becomes a metadata write that records tag-error and data-error bits for the addressed line.

Outbound, for every response the pipeline sends to the inner cache, the block combines fresh ECC check results with the line's stored metadata error bits and drives the response's denied and corrupt flags. A response that carries data always raises corrupt along with denied. A response without data never raises corrupt. The block also tells the directory whether the requester may be recorded as holding a copy: only a clean data grant allows that. ECC computation, the SRAM arrays and interrupt reporting sit outside the block.

Top module: `tl_errflag_map`

## Requirements
- R1: An inbound writeback/snoop message with corrupt=1 and opcode 5 or 7 (the data-carrying acknowledge and release) produces a metadata write with data error 1 and tag error 0.
- R2: An inbound writeback/snoop message with corrupt=1 and opcode 4 or 6 (the dataless acknowledge and release) produces a metadata write with tag error 1 and data error 0.
- R3: An inbound message with corrupt=0, or with any opcode from 0 to 3, produces a metadata write with both error bits 0.
- R4: Accepted outer fill data produces a metadata write whose tag error equals the fill's denied bit and whose data error equals its corrupt bit.
- R5: The inner-cache message takes priority over outer fill. `fill_ready` is 0 whenever `c_valid` is 1. Each accepted message produces exactly one metadata write, with the message's line index, one cycle after acceptance.
- R6: For a data-carrying response (`rsp_has_data`=1), denied and corrupt are both 1 when any of the two ECC strobes or the two stored metadata error bits is 1. Otherwise both are 0.
- R7: For a dataless response, denied is 1 when any of the four error inputs is 1, and corrupt is always 0.
- R8: `d_hold_copy` is 1 only for a data-carrying response with no error. A denied response never records the requester as a holder.
- R9: With the default registered output stage, a response accepted on `rsp_valid && rsp_ready` appears on the D outputs one cycle later. While `d_valid` is 1 and `d_ready` is 0, the outputs stay unchanged. `rsp_ready` equals `!d_valid || d_ready`.
- R10: After reset, `d_valid` and `meta_wr_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c_valid | input | 1 | Inner-cache writeback/snoop message valid (always accepted) |
| c_opcode | input | 3 | Message opcode |
| c_corrupt | input | 1 | Single error bit carried by the message |
| c_idx | input | IDX_W | Line index of the message |
| fill_valid | input | 1 | Outer fill data valid |
| fill_ready | output | 1 | Fill accepted this cycle |
| fill_denied | input | 1 | Fill denied bit |
| fill_corrupt | input | 1 | Fill corrupt bit |
| fill_idx | input | IDX_W | Line index of the fill |
| meta_wr_valid | output | 1 | Metadata write strobe |
| meta_wr_idx | output | IDX_W | Line index to write |
| meta_wr_tag_err | output | 1 | Tag-error bit to store |
| meta_wr_data_err | output | 1 | Data-error bit to store |
| rsp_valid | input | 1 | Pipeline response valid |
| rsp_ready | output | 1 | Pipeline response accepted |
| rsp_has_data | input | 1 | Response carries data |
| rsp_idx | input | IDX_W | Line index of the response |
| ecc_tag_err | input | 1 | Fresh tag ECC error strobe |
| ecc_data_err | input | 1 | Fresh data ECC error strobe |
| meta_tag_err | input | 1 | Stored tag-error bit of the line |
| meta_data_err | input | 1 | Stored data-error bit of the line |
| d_valid | output | 1 | D channel response valid |
| d_ready | input | 1 | D channel response accepted downstream |
| d_has_data | output | 1 | Response carries data |
| d_idx | output | IDX_W | Line index of the response |
| d_denied | output | 1 | Denied flag |
| d_corrupt | output | 1 | Corrupt flag |
| d_hold_copy | output | 1 | Requester may be recorded as holding the line |

## Verification
A wrong opcode decode shows up on the metadata write one cycle after the message: the error lands in the wrong bit or is dropped. The bench sweeps all sixteen opcode/corrupt pairs to catch this. A broken response combine shows up on the D flags one cycle after acceptance, for instance as a denied data response that lacks corrupt, or as a holder record on a denied grant. All 32 combinations of data presence and error inputs are swept for this. A faulty output register or handshake shows up within one stalled cycle: the flags change or `rsp_ready` stays high while the downstream stalls.

// File: rtl/tlem_pkg.sv
package tlem_pkg;
   localparam int OP_W = 3;

   localparam logic [OP_W-1:0] OP_ACK_NODATA = 3'd4;
   localparam logic [OP_W-1:0] OP_ACK_DATA   = 3'd5;
   localparam logic [OP_W-1:0] OP_REL_NODATA = 3'd6;
   localparam logic [OP_W-1:0] OP_REL_DATA   = 3'd7;

   typedef struct packed {
      logic tag_err;
      logic data_err;
   } err_bits_t;
endpackage

// File: rtl/tlem_c_decode.sv
module tlem_c_decode
   import tlem_pkg::*;
(
   input  logic [OP_W-1:0] opcode,
   input  logic            corrupt,
   output err_bits_t       flags
);
   logic carries_data;
   logic dataless_resp;

   always_comb begin
      carries_data  = (opcode == OP_ACK_DATA)   || (opcode == OP_REL_DATA);
      dataless_resp = (opcode == OP_ACK_NODATA) || (opcode == OP_REL_NODATA);
      flags.data_err = corrupt && carries_data;
      flags.tag_err  = corrupt && dataless_resp;
   end
endmodule

// File: rtl/tlem_meta_wr.sv
module tlem_meta_wr
   import tlem_pkg::*;
#(
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             c_valid,
   input  logic [OP_W-1:0]  c_opcode,
   input  logic             c_corrupt,
   input  logic [IDX_W-1:0] c_idx,
   input  logic             fill_valid,
   output logic             fill_ready,
   input  logic             fill_denied,
   input  logic             fill_corrupt,
   input  logic [IDX_W-1:0] fill_idx,
   output logic             meta_wr_valid,
   output logic [IDX_W-1:0] meta_wr_idx,
   output logic             meta_wr_tag_err,
   output logic             meta_wr_data_err
);
   err_bits_t        c_flags;
   err_bits_t        sel_flags;
   logic [IDX_W-1:0] sel_idx;
   logic             take_fill;

   tlem_c_decode u_dec (
      .opcode  (c_opcode),
      .corrupt (c_corrupt),
      .flags   (c_flags)
   );

   always_comb begin
      fill_ready = !c_valid;
      take_fill  = fill_valid && !c_valid;
      if (c_valid) begin
         sel_flags = c_flags;
         sel_idx   = c_idx;
      end else begin
         sel_flags.tag_err  = fill_denied;
         sel_flags.data_err = fill_corrupt;
         sel_idx            = fill_idx;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         meta_wr_valid    <= 1'b0;
         meta_wr_idx      <= '0;
         meta_wr_tag_err  <= 1'b0;
         meta_wr_data_err <= 1'b0;
      end else begin
         meta_wr_valid <= c_valid || take_fill;
         if (c_valid || take_fill) begin
            meta_wr_idx      <= sel_idx;
            meta_wr_tag_err  <= sel_flags.tag_err;
            meta_wr_data_err <= sel_flags.data_err;
         end
      end
   end

   p_data_op_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (c_valid && c_corrupt && (c_opcode == OP_ACK_DATA || c_opcode == OP_REL_DATA))
      |=> (meta_wr_valid && meta_wr_data_err && !meta_wr_tag_err));

   p_nodata_op_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (c_valid && c_corrupt && (c_opcode == OP_ACK_NODATA || c_opcode == OP_REL_NODATA))
      |=> (meta_wr_valid && meta_wr_tag_err && !meta_wr_data_err));

   p_clean_msg_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (c_valid && !c_corrupt) |=> (meta_wr_valid && !meta_wr_tag_err && !meta_wr_data_err));

   p_fill_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      c_valid |-> !fill_ready);

   p_one_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!c_valid && !fill_valid) |=> !meta_wr_valid);
endmodule

// File: rtl/tlem_d_resp.sv
module tlem_d_resp #(
   parameter int IDX_W   = 6,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rsp_valid,
   output logic             rsp_ready,
   input  logic             rsp_has_data,
   input  logic [IDX_W-1:0] rsp_idx,
   input  logic             ecc_tag_err,
   input  logic             ecc_data_err,
   input  logic             meta_tag_err,
   input  logic             meta_data_err,
   output logic             d_valid,
   input  logic             d_ready,
   output logic             d_has_data,
   output logic [IDX_W-1:0] d_idx,
   output logic             d_denied,
   output logic             d_corrupt,
   output logic             d_hold_copy
);
   logic any_err;
   logic nx_denied;
   logic nx_corrupt;
   logic nx_hold;

   always_comb begin
      any_err    = ecc_tag_err || ecc_data_err || meta_tag_err || meta_data_err;
      nx_denied  = any_err;
      nx_corrupt = rsp_has_data && any_err;
      nx_hold    = rsp_has_data && !any_err;
   end

   generate
      if (OUT_REG) begin : g_reg
         logic             q_valid;
         logic             q_has_data;
         logic [IDX_W-1:0] q_idx;
         logic             q_denied;
         logic             q_corrupt;
         logic             q_hold;
         logic             load;

         assign load = !q_valid || d_ready;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q_valid    <= 1'b0;
               q_has_data <= 1'b0;
               q_idx      <= '0;
               q_denied   <= 1'b0;
               q_corrupt  <= 1'b0;
               q_hold     <= 1'b0;
            end else if (load) begin
               q_valid <= rsp_valid;
               if (rsp_valid) begin
                  q_has_data <= rsp_has_data;
                  q_idx      <= rsp_idx;
                  q_denied   <= nx_denied;
                  q_corrupt  <= nx_corrupt;
                  q_hold     <= nx_hold;
               end
            end
         end

         assign rsp_ready   = load;
         assign d_valid     = q_valid;
         assign d_has_data  = q_has_data;
         assign d_idx       = q_idx;
         assign d_denied    = q_denied;
         assign d_corrupt   = q_corrupt;
         assign d_hold_copy = q_hold;

         p_tag_ecc_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (rsp_valid && rsp_ready && rsp_has_data && ecc_tag_err)
            |=> (d_valid && d_denied && d_corrupt));

         p_stall_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (d_valid && !d_ready)
            |=> (d_valid && $stable(d_denied) && $stable(d_corrupt)
                 && $stable(d_idx) && $stable(d_hold_copy)));
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk  = clk ^ rst_n;
         assign rsp_ready   = d_ready;
         assign d_valid     = rsp_valid;
         assign d_has_data  = rsp_has_data;
         assign d_idx       = rsp_idx;
         assign d_denied    = nx_denied;
         assign d_corrupt   = nx_corrupt;
         assign d_hold_copy = nx_hold;
      end
   endgenerate

   p_denied_corrupt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (d_valid && d_has_data && d_denied) |-> d_corrupt);

   p_nodata_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (d_valid && !d_has_data) |-> !d_corrupt);

   p_hold_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (d_valid && d_hold_copy) |-> (!d_denied && d_has_data));
endmodule

// File: rtl/tl_errflag_map.sv
module tl_errflag_map
   import tlem_pkg::*;
#(
   parameter int IDX_W   = 6,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             c_valid,
   input  logic [2:0]       c_opcode,
   input  logic             c_corrupt,
   input  logic [IDX_W-1:0] c_idx,
   input  logic             fill_valid,
   output logic             fill_ready,
   input  logic             fill_denied,
   input  logic             fill_corrupt,
   input  logic [IDX_W-1:0] fill_idx,
   output logic             meta_wr_valid,
   output logic [IDX_W-1:0] meta_wr_idx,
   output logic             meta_wr_tag_err,
   output logic             meta_wr_data_err,
   input  logic             rsp_valid,
   output logic             rsp_ready,
   input  logic             rsp_has_data,
   input  logic [IDX_W-1:0] rsp_idx,
   input  logic             ecc_tag_err,
   input  logic             ecc_data_err,
   input  logic             meta_tag_err,
   input  logic             meta_data_err,
   output logic             d_valid,
   input  logic             d_ready,
   output logic             d_has_data,
   output logic [IDX_W-1:0] d_idx,
   output logic             d_denied,
   output logic             d_corrupt,
   output logic             d_hold_copy
);
   generate
      if (IDX_W < 1 || IDX_W > 32) begin : g_bad_idx
         $error("IDX_W must lie in 1..32");
      end
      if (OP_W != 3) begin : g_bad_op
         $error("opcode width must be 3");
      end
   endgenerate

   tlem_meta_wr #(.IDX_W(IDX_W)) u_meta (
      .clk              (clk),
      .rst_n            (rst_n),
      .c_valid          (c_valid),
      .c_opcode         (c_opcode),
      .c_corrupt        (c_corrupt),
      .c_idx            (c_idx),
      .fill_valid       (fill_valid),
      .fill_ready       (fill_ready),
      .fill_denied      (fill_denied),
      .fill_corrupt     (fill_corrupt),
      .fill_idx         (fill_idx),
      .meta_wr_valid    (meta_wr_valid),
      .meta_wr_idx      (meta_wr_idx),
      .meta_wr_tag_err  (meta_wr_tag_err),
      .meta_wr_data_err (meta_wr_data_err)
   );

   tlem_d_resp #(.IDX_W(IDX_W), .OUT_REG(OUT_REG)) u_resp (
      .clk           (clk),
      .rst_n         (rst_n),
      .rsp_valid     (rsp_valid),
      .rsp_ready     (rsp_ready),
      .rsp_has_data  (rsp_has_data),
      .rsp_idx       (rsp_idx),
      .ecc_tag_err   (ecc_tag_err),
      .ecc_data_err  (ecc_data_err),
      .meta_tag_err  (meta_tag_err),
      .meta_data_err (meta_data_err),
      .d_valid       (d_valid),
      .d_ready       (d_ready),
      .d_has_data    (d_has_data),
      .d_idx         (d_idx),
      .d_denied      (d_denied),
      .d_corrupt     (d_corrupt),
      .d_hold_copy   (d_hold_copy)
   );

   p_reset_idle_r10: assert property (@(posedge clk)
      !rst_n |=> (!d_valid && !meta_wr_valid));
endmodule

// File: tb/tl_errflag_map_bench.sv
module tl_errflag_map_bench;
   localparam int IDX_W = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             c_valid = 1'b0;
   logic [2:0]       c_opcode = '0;
   logic             c_corrupt = 1'b0;
   logic [IDX_W-1:0] c_idx = '0;
   logic             fill_valid = 1'b0;
   logic             fill_ready;
   logic             fill_denied = 1'b0;
   logic             fill_corrupt = 1'b0;
   logic [IDX_W-1:0] fill_idx = '0;
   logic             meta_wr_valid;
   logic [IDX_W-1:0] meta_wr_idx;
   logic             meta_wr_tag_err;
   logic             meta_wr_data_err;
   logic             rsp_valid = 1'b0;
   logic             rsp_ready;
   logic             rsp_has_data = 1'b0;
   logic [IDX_W-1:0] rsp_idx = '0;
   logic             ecc_tag_err = 1'b0;
   logic             ecc_data_err = 1'b0;
   logic             meta_tag_err = 1'b0;
   logic             meta_data_err = 1'b0;
   logic             d_valid;
   logic             d_ready = 1'b1;
   logic             d_has_data;
   logic [IDX_W-1:0] d_idx;
   logic             d_denied;
   logic             d_corrupt;
   logic             d_hold_copy;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   tl_errflag_map #(.IDX_W(IDX_W), .OUT_REG(1'b1)) u_tl_errflag_map (.*);

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      for (int i = 0; i < 20000; i++) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         report();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(d_valid == 1'b0, "R10", "d_valid", int'(d_valid), 0);
      chk(meta_wr_valid == 1'b0, "R10", "meta_wr_valid", int'(meta_wr_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1/R2/R3: every opcode with both corrupt values
      for (int op = 0; op < 8; op++) begin
         for (int cr = 0; cr < 2; cr++) begin
            bit exp_d, exp_t;
            int got, exp;
            exp_d = (cr == 1) && (op == 5 || op == 7);
            exp_t = (cr == 1) && (op == 4 || op == 6);
            c_valid = 1'b1; c_opcode = 3'(op); c_corrupt = cr[0];
            c_idx = IDX_W'(op * 2 + cr + 3);
            @(negedge clk);
            c_valid = 1'b0;
            got = {meta_wr_valid, meta_wr_tag_err, meta_wr_data_err, meta_wr_idx};
            exp = {1'b1, exp_t, exp_d, IDX_W'(op * 2 + cr + 3)};
            chk(got == exp,
                exp_d ? "R1" : (exp_t ? "R2" : "R3"), "c-channel meta write", got, exp);
         end
      end
      @(negedge clk);
      chk(meta_wr_valid == 1'b0, "R5", "no write when idle", int'(meta_wr_valid), 0);

      // R4: fill denied/corrupt combinations
      for (int k = 0; k < 4; k++) begin
         int got, exp;
         fill_valid = 1'b1; fill_denied = k[1]; fill_corrupt = k[0];
         fill_idx = IDX_W'(40 + k);
         #1;
         chk(fill_ready == 1'b1, "R5", "fill_ready idle", int'(fill_ready), 1);
         @(negedge clk);
         fill_valid = 1'b0;
         got = {meta_wr_valid, meta_wr_tag_err, meta_wr_data_err, meta_wr_idx};
         exp = {1'b1, k[1], k[0], IDX_W'(40 + k)};
         chk(got == exp, "R4", "fill meta write", got, exp);
      end

      // R5: simultaneous inner message and fill
      c_valid = 1'b1; c_opcode = 3'd7; c_corrupt = 1'b1; c_idx = 6'd9;
      fill_valid = 1'b1; fill_denied = 1'b1; fill_corrupt = 1'b0; fill_idx = 6'd50;
      #1;
      chk(fill_ready == 1'b0, "R5", "fill_ready under contention", int'(fill_ready), 0);
      @(negedge clk);
      c_valid = 1'b0;
      begin
         int got, exp;
         got = {meta_wr_tag_err, meta_wr_data_err, meta_wr_idx};
         exp = {1'b0, 1'b1, 6'd9};
         chk(got == exp, "R5", "inner message wins", got, exp);
      end
      @(negedge clk);
      fill_valid = 1'b0;
      begin
         int got, exp;
         got = {meta_wr_valid, meta_wr_tag_err, meta_wr_data_err, meta_wr_idx};
         exp = {1'b1, 1'b1, 1'b0, 6'd50};
         chk(got == exp, "R5", "stalled fill follows", got, exp);
      end
      @(negedge clk);

      // R6/R7/R8: all response input combinations
      for (int v = 0; v < 32; v++) begin
         bit hd, any;
         int got, exp;
         hd  = v[4];
         any = |v[3:0];
         rsp_valid = 1'b1; rsp_has_data = hd;
         {ecc_tag_err, ecc_data_err, meta_tag_err, meta_data_err} = v[3:0];
         rsp_idx = IDX_W'(v);
         #1;
         chk(rsp_ready == 1'b1, "R9", "rsp_ready", int'(rsp_ready), 1);
         @(negedge clk);
         rsp_valid = 1'b0;
         got = {d_valid, d_has_data, d_denied, d_corrupt, d_hold_copy, d_idx};
         exp = {1'b1, hd, any, hd & any, hd & ~any, IDX_W'(v)};
         chk(got == exp, hd ? (any ? "R6" : "R8") : "R7", "response flags", got, exp);
      end
      @(negedge clk);
      chk(d_valid == 1'b0, "R9", "d_valid drops", int'(d_valid), 0);

      // R9: backpressure keeps outputs stable
      d_ready = 1'b0;
      rsp_valid = 1'b1; rsp_has_data = 1'b1; rsp_idx = 6'd33;
      {ecc_tag_err, ecc_data_err, meta_tag_err, meta_data_err} = 4'b0010;
      @(negedge clk);
      chk(rsp_ready == 1'b0, "R9", "rsp_ready under stall", int'(rsp_ready), 0);
      rsp_has_data = 1'b0; rsp_idx = 6'd12;
      {ecc_tag_err, ecc_data_err, meta_tag_err, meta_data_err} = 4'b0000;
      @(negedge clk);
      begin
         int got, exp;
         got = {d_valid, d_has_data, d_denied, d_corrupt, d_hold_copy, d_idx};
         exp = {1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 6'd33};
         chk(got == exp, "R9", "held response", got, exp);
      end
      d_ready = 1'b1;
      #1;
      chk(rsp_ready == 1'b1, "R9", "rsp_ready on release", int'(rsp_ready), 1);
      @(negedge clk);
      rsp_valid = 1'b0;
      begin
         int got, exp;
         got = {d_valid, d_has_data, d_denied, d_corrupt, d_hold_copy, d_idx};
         exp = {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd12};
         chk(got == exp, "R9", "next response after stall", got, exp);
      end
      @(negedge clk);

      done = 1'b1;
      report();
   end
endmodule